// File: doc/BRIEF.md
# SPI Transaction Master

This block is the shift engine of an SPI bus master for 8-bit frames. It generates the serial clock from the system clock, shifts one byte out on MOSI while it shifts one byte in from MISO, and drives an active-low select line. All four clock formats are available: one control sets the idle level of SCK and another sets whether data is captured on the first or the second clock edge of each bit time. A third control picks whether the most or the least significant bit travels first, and that order applies in both directions.

Several bytes can make up one transaction. The host loads a byte with a one-cycle start strobe and marks the final byte with a last flag. The select line falls when the first byte is accepted and stays low through every following byte. It rises only after the final edge of the flagged byte. A done pulse and the received byte come back after every byte. Between bytes the engine waits with select low until the host supplies the next one. The format controls and the clock divider are captured when a transaction opens and hold until it closes.

Top module: `spi_txn_master`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ss_n` is 1, `busy` is 0, `done` is 0 and `sck` sits at the idle level given by `cfg_cpol`. A reset in the middle of a byte aborts the transfer.
- R2: Every SCK half-period lasts `cfg_div`+1 system clocks. The first SCK edge comes one half-period after the byte is accepted.
- R3: SCK idles low when `cfg_cpol`=0 and high when `cfg_cpol`=1. Each byte has exactly 16 SCK transitions, so SCK is back at its idle level when the byte ends.
- R4: With `cfg_cpha`=0, the first data bit is on MOSI from the cycle after acceptance, before any SCK edge. MISO is sampled on the 1st, 3rd, ... 15th transitions, and MOSI advances on the even-numbered ones.
- R5: With `cfg_cpha`=1, MOSI advances on the 1st, 3rd, ... transitions, and MISO is sampled on the 2nd, 4th, ... 16th transitions.
- R6: With `cfg_lsb_first`=1, bit 0 is sent first and the first received bit lands in `rx_data` bit 0. With `cfg_lsb_first`=0, bit 7 goes first both ways.
- R7: `ss_n` goes low in the cycle after the first byte is accepted and stays low through all bytes of the transaction, including the idle time between bytes.
- R8: After the final transition of a byte accepted with `tx_last`=1, `ss_n` rises `cfg_div`+1 clocks later. `busy` falls a further `cfg_div`+1 clocks after that.
- R9: `done` is a one-clock pulse that is visible 16×(`cfg_div`+1) clocks after acceptance. While it is high, `rx_data` holds the received byte.
- R10: `cfg_cpol`, `cfg_cpha`, `cfg_lsb_first` and `cfg_div` are captured when a transaction's first byte is accepted. Later changes have no effect until the transaction ends, including changes made between bytes.
- R11: `busy` is 1 from acceptance until `done` for a non-final byte, or until the trailing guard time ends for the final byte. A `tx_start` strobe while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: capture on first edge of bit time; 1: on second edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_div | input | 8 | SCK half-period minus one, in system clocks |
| tx_start | input | 1 | Strobe: accept `tx_data` when not busy |
| tx_data | input | 8 | Byte to transmit |
| tx_last | input | 1 | Marks the accepted byte as the final one of the transaction |
| busy | output | 1 | Engine is occupied; strobes are ignored |
| done | output | 1 | One-cycle pulse at the end of each byte |
| rx_data | output | 8 | Byte received during the last completed frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low select |

## Verification
After a strobe is accepted at a clock edge, select and the first MOSI bit show one cycle later. The done pulse shows exactly 16×(div+1) cycles after acceptance. The rise of select and the fall of busy each follow the previous event by div+1 cycles. The bench samples on the falling clock edge and counts falling edges from the strobe, so every check lands on the one cycle where its result is due. A model slave in the bench follows the SCK transitions at the ports to check the bits and their order.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_XFER,
      ST_HOLD,
      ST_TRAIL,
      ST_GUARD
   } seq_state_t;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } spi_fmt_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt <= div)); // R2

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
   import spi_txn_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int EW     = $clog2(2 * DATA_W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          start,
   input  logic          last,
   output seq_state_t    state,
   output logic          ss_n,
   output logic          sck_raw,
   output logic          edge_fire,
   output logic [EW-1:0] edge_idx,
   output logic          busy,
   output logic          done,
   output logic          load,
   output logic          latch_cfg
);

   localparam int EDGES = 2 * DATA_W;
   localparam logic [EW-1:0] FINAL_EDGE = EW'(EDGES - 1);

   logic [EW-1:0] edge_cnt;
   logic          last_q;
   logic          ready;

   assign ready     = (state == ST_IDLE) || (state == ST_HOLD);
   assign busy      = !ready;
   assign load      = start && ready;
   assign latch_cfg = start && (state == ST_IDLE);
   assign edge_fire = tick && ((state == ST_LEAD) || (state == ST_XFER));
   assign edge_idx  = edge_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         ss_n     <= 1'b1;
         sck_raw  <= 1'b0;
         edge_cnt <= '0;
         done     <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE, ST_HOLD: begin
               if (load) begin
                  state    <= ST_LEAD;
                  ss_n     <= 1'b0;
                  edge_cnt <= '0;
                  last_q   <= last;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sck_raw  <= ~sck_raw;
                  edge_cnt <= edge_cnt + 1'b1;
                  state    <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (tick) begin
                  sck_raw  <= ~sck_raw;
                  edge_cnt <= edge_cnt + 1'b1;
                  if (edge_cnt == FINAL_EDGE) begin
                     done  <= 1'b1;
                     state <= last_q ? ST_TRAIL : ST_HOLD;
                  end
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  ss_n  <= 1'b1;
                  state <= ST_GUARD;
               end
            end
            ST_GUARD: begin
               if (tick) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_HOLD_KEEPS_SELECT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD) |-> !ss_n); // R7

   AST_GUARD_SELECT_HIGH: assert property (@(posedge clk) disable iff (rst)
      (state == ST_GUARD) |-> ss_n); // R8

   AST_IDLE_SCK_PARKED: assert property (@(posedge clk) disable iff (rst)
      ready |-> !sck_raw); // R3

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_lsb,
   input  logic              rx_lsb,
   input  logic              shift_out,
   input  logic              sample_in,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data
);

   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] load_rev;
   logic [DATA_W-1:0] rx_rev;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign load_rev[i] = load_data[DATA_W-1-i];
      assign rx_rev[i]   = rx_sr[DATA_W-1-i];
   end

   assign mosi    = tx_sr[DATA_W-1];
   assign rx_data = rx_lsb ? rx_rev : rx_sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else begin
         if (load) begin
            tx_sr <= load_lsb ? load_rev : load_data;
         end else if (shift_out) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         end
         if (sample_in) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
         end
      end
   end

   AST_NO_SHIFT_AND_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |-> !sample_in); // R11

endmodule

// File: rtl/spi_txn_master.sv
module spi_txn_master
   import spi_txn_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_last,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              ss_n
);

   localparam int EW = $clog2(2 * DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_txn_master: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_txn_master: DIV_W must be at least 1");
   end

   seq_state_t       state;
   spi_fmt_t         fmt_q;
   logic [DIV_W-1:0] div_q;
   logic             tick;
   logic             sck_raw;
   logic             edge_fire;
   logic [EW-1:0]    edge_idx;
   logic             load;
   logic             latch_cfg;
   logic             sample_now;
   logic             shift_now;
   logic             idle_level;

   always_ff @(posedge clk) begin
      if (rst) begin
         fmt_q <= '0;
         div_q <= '0;
      end else if (latch_cfg) begin
         fmt_q <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
         div_q <= cfg_div;
      end
   end

   spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (busy),
      .div  (div_q),
      .tick (tick)
   );

   spi_seq_ctrl #(.DATA_W(DATA_W), .EW(EW)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .start     (tx_start),
      .last      (tx_last),
      .state     (state),
      .ss_n      (ss_n),
      .sck_raw   (sck_raw),
      .edge_fire (edge_fire),
      .edge_idx  (edge_idx),
      .busy      (busy),
      .done      (done),
      .load      (load),
      .latch_cfg (latch_cfg)
   );

   assign sample_now = edge_fire && (edge_idx[0] == fmt_q.cpha);
   assign shift_now  = edge_fire && (edge_idx[0] != fmt_q.cpha)
                       && !(fmt_q.cpha && (edge_idx == '0));

   spi_bit_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_data (tx_data),
      .load_lsb  (latch_cfg ? cfg_lsb_first : fmt_q.lsb_first),
      .rx_lsb    (fmt_q.lsb_first),
      .shift_out (shift_now),
      .sample_in (sample_now),
      .miso      (miso),
      .mosi      (mosi),
      .rx_data   (rx_data)
   );

   assign idle_level = (state == ST_IDLE) ? cfg_cpol : fmt_q.cpol;
   assign sck        = sck_raw ^ idle_level;

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ($stable(fmt_q) && $stable(div_q))); // R10

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R9

   AST_DONE_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> (sck == fmt_q.cpol)); // R3

   AST_EDGE_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
      edge_fire |-> !ss_n); // R7

endmodule

// File: tb/spi_txn_master_test.sv
module spi_txn_master_test;

   logic       clk = 1'b0;
   logic       rst;
   logic       cfg_cpol, cfg_cpha, cfg_lsb_first;
   logic [7:0] cfg_div;
   logic       tx_start;
   logic [7:0] tx_data;
   logic       tx_last;
   logic       busy, done, sck, mosi, ss_n;
   logic [7:0] rx_data;
   logic       miso;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   spi_txn_master uut (
      .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .tx_start(tx_start),
      .tx_data(tx_data), .tx_last(tx_last), .busy(busy), .done(done),
      .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   // intended format of the current transaction, kept apart from the inputs
   logic       t_cpol, t_cpha, t_lsb;
   int         t_div;
   logic [7:0] m_tx [4];
   logic [7:0] s_tx [4];
   logic [7:0] s_rx [4];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sbit(input int b, input int i);
      logic [7:0] v;
      v = s_tx[b];
      return t_lsb ? v[i] : v[7-i];
   endfunction

   // model slave: follows SCK transitions seen at the ports
   logic sck_d = 1'b0;
   logic ss_d = 1'b1;
   int   ec = 0;
   int   sb = 0;
   always @(negedge clk) begin
      if (ss_d && !ss_n) begin
         ec = 0;
         sb = 0;
         for (int b = 0; b < 4; b++) s_rx[b] = 8'h00;
         if (!t_cpha) miso = sbit(0, 0);
      end
      if (!ss_n && (sck !== sck_d) && sb < 3) begin
         if ((ec % 2) == int'(t_cpha)) begin
            s_rx[sb][t_lsb ? (ec/2) : (7 - ec/2)] = mosi;
         end else if (t_cpha) begin
            miso = sbit(sb, ec/2);
         end else if (ec == 15) begin
            miso = sbit(sb + 1, 0);
         end else begin
            miso = sbit(sb, (ec + 1)/2);
         end
         if (ec == 15) begin
            ec = 0;
            sb++;
         end else begin
            ec++;
         end
      end
      sck_d = sck;
      ss_d  = ss_n;
   end

   task automatic run_txn(input logic cp, input logic ph, input logic lf,
                          input int dv, input bit flip, input bit poke);
      int k;
      int j;
      int bad;
      t_cpol = cp; t_cpha = ph; t_lsb = lf; t_div = dv;
      for (int i = 0; i < 4; i++) begin
         m_tx[i] = 8'h5A ^ 8'(i * 37 + dv * 11 + int'(cp) * 3 + int'(ph) * 64 + int'(lf) * 128);
         s_tx[i] = 8'hC3 + 8'(i * 71 + dv * 5 + int'(ph) * 17 + int'(lf) * 40 + int'(cp));
      end
      @(negedge clk);
      cfg_cpol = cp; cfg_cpha = ph; cfg_lsb_first = lf; cfg_div = 8'(dv);
      @(negedge clk);
      chk(sck == cp, "R3 idle level before start", int'(sck), int'(cp));
      for (int i = 0; i < 3; i++) begin
         if (flip && i == 1) begin
            cfg_cpol = ~cp; cfg_cpha = ~ph; cfg_lsb_first = ~lf; cfg_div = 8'(dv + 2);
            @(negedge clk);
            chk(sck == cp, "R10 sck ignores cpol change between bytes", int'(sck), int'(cp));
         end
         if (i == 0) chk(busy == 1'b0, "R11 ready before start", int'(busy), 0);
         tx_data = m_tx[i];
         tx_last = (i == 2);
         tx_start = 1'b1;
         @(negedge clk);
         tx_start = 1'b0;
         k = 1;
         bad = 0;
         chk(ss_n == 1'b0, "R7 select low after accept", int'(ss_n), 0);
         chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
         if (!ph) chk(mosi == (lf ? m_tx[i][0] : m_tx[i][7]),
                      "R4 first bit on mosi before any edge", int'(mosi),
                      int'(lf ? m_tx[i][0] : m_tx[i][7]));
         while (!done && k < 4000) begin
            @(negedge clk);
            k++;
            if (poke && k == 3) begin
               tx_start = 1'b1;
               tx_data = ~m_tx[i];
            end else begin
               tx_start = 1'b0;
            end
            if (!done && (ss_n || !busy)) bad++;
         end
         tx_start = 1'b0;
         chk(k == 16 * (dv + 1) + 1, "R2 R9 done timing", k, 16 * (dv + 1) + 1);
         chk(bad == 0, "R7 R11 select and busy held within byte", bad, 0);
         chk(rx_data == s_tx[i], ph ? "R5 R6 received byte" : "R4 R6 received byte",
             int'(rx_data), int'(s_tx[i]));
         chk(sck == cp, "R3 sck idle at byte end", int'(sck), int'(cp));
         @(negedge clk);
         j = 1;
         chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
         chk(s_rx[i] == m_tx[i], ph ? "R5 R6 slave got byte" : "R4 R6 slave got byte",
             int'(s_rx[i]), int'(m_tx[i]));
         if (i < 2) begin
            @(negedge clk);
            chk(ss_n == 1'b0, "R7 select held between bytes", int'(ss_n), 0);
            chk(busy == 1'b0, "R11 ready between bytes", int'(busy), 0);
         end else begin
            while (!ss_n && j < 4000) begin
               @(negedge clk);
               j++;
            end
            chk(j == dv + 1, "R8 select release delay", j, dv + 1);
            k = 0;
            while (busy && k < 4000) begin
               @(negedge clk);
               k++;
            end
            chk(k == dv + 1, "R8 guard before ready", k, dv + 1);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_div = 8'd1;
      tx_start = 1'b0; tx_data = 8'h00; tx_last = 1'b0; miso = 1'b0;
      t_cpol = 1'b1; t_cpha = 1'b0; t_lsb = 1'b0; t_div = 1;
      for (int b = 0; b < 4; b++) begin
         m_tx[b] = 8'h00; s_tx[b] = 8'h00; s_rx[b] = 8'h00;
      end
      repeat (3) @(negedge clk);
      chk(sck == 1'b1 && ss_n == 1'b1 && busy == 1'b0 && done == 1'b0,
          "R1 reset state", int'({sck, ss_n, busy, done}), 4'b1100);
      rst = 1'b0;
      @(negedge clk);
      chk(ss_n == 1'b1, "R1 select high after reset", int'(ss_n), 1);

      for (int cp = 0; cp < 2; cp++)
         for (int ph = 0; ph < 2; ph++)
            for (int lf = 0; lf < 2; lf++)
               for (int d = 0; d < 3; d++)
                  run_txn(cp[0], ph[0], lf[0], (d == 2) ? 3 : d, d == 1, d == 2);

      // abort by reset in the middle of a byte
      cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b0; cfg_div = 8'd1;
      t_cpol = 1'b1; t_cpha = 1'b1; t_lsb = 1'b0; t_div = 1;
      @(negedge clk);
      tx_data = 8'hA5; tx_last = 1'b0; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      repeat (9) @(negedge clk);
      chk(ss_n == 1'b0 && busy == 1'b1, "R1 mid-byte before reset", int'({ss_n, busy}), 1);
      rst = 1'b1;
      @(negedge clk);
      chk(sck == 1'b1 && ss_n == 1'b1 && busy == 1'b0 && done == 1'b0,
          "R1 reset aborts byte", int'({sck, ss_n, busy, done}), 4'b1100);
      rst = 1'b0;
      @(negedge clk);
      chk(ss_n == 1'b1 && busy == 1'b0, "R1 idle after abort", int'({ss_n, busy}), 2'b10);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule